// File: doc/BRIEF.md
# Virtual Function Capability Register File

This block holds the single-root I/O virtualization extended capability of a physical function. Configuration software reaches it through a 32-bit, byte-enabled configuration port. The port carries an absolute configuration-space byte address, and the block claims only the dwords that fall inside its capability window. The window holds a control word, three virtual-function counts, the routing offset and stride of the first virtual function, the device identifier that virtual functions report, the supported page sizes and the chosen system page size.

Each writable field has its own per-bit write mask. Every byte lane that a write enables is merged as `(old & ~mask) | (new & mask)`. A write that covers the enable bit of the control word starts or ends the virtual-function population. Starting it latches the current requested count into `active_vfs` and pulses `vf_create_pulse`. Ending it zeroes the active count, forces the requested count back to zero and pulses `vf_teardown_pulse`. A separate `disable_req` input gives the platform the same teardown without a configuration write. Reads are combinational. The block does not create the virtual functions itself; a neighbouring block acts on its outputs.

Top module: `vfcap_regfile`

## Requirements
- R1: The control word is at window offset 0x00, bits [15:0]. Only bit 0 (enable), bit 3 (memory space enable) and bit 4 (hierarchy capable) are writable. Every other bit, including [31:16], reads zero. Reset value is 0.
- R2: The requested count is at offset 0x08, bits [15:0]. All 16 bits are writable and reset to 0. Bits [31:16] read zero.
- R3: The system page size is at offset 0x18, bits [15:0]. It resets to 0x0001, and its write mask equals the supported-page-size value.
- R4: The supported page sizes are at offset 0x14, bits [15:0]. The field is read-only and reads 0x0553 ORed with parameter `EXTRA_PG` (0x0557 by default).
- R5: The following fields are read-only and set by parameters; writes to them have no effect. Offset 0x04 holds the initial count in [15:0] and the total count in [31:16]. Offset 0x0C holds the first-function offset in [15:0] and the stride in [31:16]. Offset 0x10 holds the device identifier in [31:16], with zero in [15:0].
- R6: A write with byte enable 0 set at offset 0x00 that sets bit 0 while `active_vfs` is 0 latches the requested count into `active_vfs` on the next cycle. `vfs_enabled` is high while `active_vfs` is nonzero. `vf_create_pulse` is high for exactly one cycle, and only when the latched count is nonzero.
- R7: While `active_vfs` is nonzero, a control write that clears bit 0 zeroes `active_vfs` and the requested count on the next cycle. It also pulses `vf_teardown_pulse` for one cycle.
- R8: A write below `CAP_BASE`, or at or beyond `CAP_BASE + CAP_BYTES`, changes nothing. This holds even when its low address bits match a field. A read there returns 0, as does a read of the unused dword at offset 0x1C.
- R9: When control bit 0 is set, a cycle of `disable_req` clears that bit and keeps the other control bits. It acts as R7 if functions are active, and any configuration write in the same cycle is dropped. When bit 0 is clear, `disable_req` does nothing.
- R10: Only the byte lanes whose `cfg_be` bit is set are written. A control write that does not enable lane 0 does not start or end functions.
- R11: While `active_vfs` is nonzero, a control write that keeps bit 0 set leaves `active_vfs` unchanged, even if the requested count has changed since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe, one write per cycle |
| cfg_addr | input | 12 | Configuration-space byte address |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| disable_req | input | 1 | Platform request to clear the enable bit |
| vfs_enabled | output | 1 | High while virtual functions are active |
| active_vfs | output | 16 | Latched active function count |
| vf_create_pulse | output | 1 | One-cycle pulse when functions are created |
| vf_teardown_pulse | output | 1 | One-cycle pulse when functions are torn down |

## Verification
The assertions assume at most one write per cycle, a dword-aligned address whose low two bits are ignored, and inputs that settle before the rising edge. The stimulus changes every input on the falling edge and holds `cfg_wr` and `disable_req` high for exactly one cycle. The out-of-window check expects `disable_req` to be low during the stray write, and the bench keeps it low there. The idle-disable check expects no write alongside the request, so the bench pulses `disable_req` alone whenever the enable bit is clear.

// File: rtl/vfcap_pkg.sv
package vfcap_pkg;

  localparam int unsigned FIELD_W = 16;

  // dword slots inside the capability window
  localparam int unsigned DW_CTRL  = 0;
  localparam int unsigned DW_COUNT = 1;
  localparam int unsigned DW_NUMVF = 2;
  localparam int unsigned DW_ROUTE = 3;
  localparam int unsigned DW_DEVID = 4;
  localparam int unsigned DW_SUPPG = 5;
  localparam int unsigned DW_SYSPG = 6;
  localparam int unsigned DW_USED  = 7;

  // control word bit positions, decoded by software
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_MEM_BIT = 3;
  localparam int unsigned CTRL_HIER_BIT = 4;

  localparam logic [FIELD_W-1:0] CTRL_WMASK =
    FIELD_W'((1 << CTRL_EN_BIT) | (1 << CTRL_MEM_BIT) | (1 << CTRL_HIER_BIT));
  localparam logic [FIELD_W-1:0] PG_MINREQ  = 16'h0553;
  localparam logic [FIELD_W-1:0] SYSPG_RST  = 16'h0001;

endpackage

// File: rtl/vfcap_decode.sv
module vfcap_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CAP_BASE  = 12'h160,
  parameter int unsigned CAP_BYTES = 32
) (
  input  logic [ADDR_W-1:0]                   addr,
  output logic                                hit,
  output logic [$clog2(CAP_BYTES/4)-1:0]      idx,
  output logic [CAP_BYTES/4-1:0]              sel
);
  localparam int unsigned NDW   = CAP_BYTES / 4;
  localparam int unsigned IDX_W = $clog2(NDW);
  localparam int unsigned DWA_W = ADDR_W - 2;
  localparam logic [DWA_W-1:0] BASE_DW = DWA_W'(CAP_BASE / 4);
  localparam logic [DWA_W-1:0] SIZE_DW = DWA_W'(NDW);

  logic [DWA_W-1:0] dw_addr;
  logic [DWA_W-1:0] dw_rel;
  logic             unused_lsb;

  always_comb begin
    dw_addr    = addr[ADDR_W-1:2];
    dw_rel     = dw_addr - BASE_DW;
    hit        = (dw_addr >= BASE_DW) && (dw_rel < SIZE_DW);
    idx        = dw_rel[IDX_W-1:0];
    unused_lsb = ^addr[1:0];
  end

  for (genvar g = 0; g < NDW; g++) begin : g_sel
    assign sel[g] = hit && (idx == IDX_W'(g));
  end

endmodule

// File: rtl/vfcap_masked_reg.sv
module vfcap_masked_reg #(
  parameter int unsigned          W    = 16,
  parameter logic [W-1:0]         MASK = '1,
  parameter logic [W-1:0]         RST  = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [W/8-1:0] byte_en,
  input  logic [W-1:0]   d,
  input  logic           clr,
  output logic [W-1:0]   q
);
  logic [W-1:0] bit_en;
  logic [W-1:0] q_nxt;
  logic         q_ce;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign bit_en[b] = we && byte_en[b/8] && MASK[b];
  end

  always_comb begin
    q_ce  = clr || we;
    q_nxt = q;
    if (clr)
      q_nxt = '0;
    else
      q_nxt = (q & ~bit_en) | (d & bit_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= RST;
    else if (q_ce)
      q <= q_nxt;
  end

  AST_LOCKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~MASK) == (RST & ~MASK & {W{1'b1}}) || $past(clr)) // R1
    else $error("locked bits of register changed");

endmodule

// File: rtl/vfcap_enable_ctl.sv
module vfcap_enable_ctl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_cmd,
  input  logic             new_en,
  input  logic [CNT_W-1:0] req_cnt,
  output logic             teardown_now,
  output logic [CNT_W-1:0] active_cnt,
  output logic             enabled,
  output logic             create_pulse,
  output logic             teardown_pulse
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_ce;
  logic             create_now;
  logic             is_active;

  always_comb begin
    is_active    = (active_cnt != '0);
    teardown_now = ctrl_cmd && is_active && !new_en;
    create_now   = ctrl_cmd && !is_active && new_en && (req_cnt != '0);
    cnt_ce       = teardown_now || create_now;
    cnt_nxt      = teardown_now ? '0 : req_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_cnt     <= '0;
      create_pulse   <= 1'b0;
      teardown_pulse <= 1'b0;
    end else begin
      create_pulse   <= create_now;
      teardown_pulse <= teardown_now;
      if (cnt_ce)
        active_cnt <= cnt_nxt;
    end
  end

  assign enabled = is_active;

  AST_LATCH_REQ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_cmd && !is_active && new_en) |=> (active_cnt == $past(req_cnt))) // R6
    else $error("requested count not latched");

  AST_PULSE_ONLY_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    create_pulse |-> (active_cnt != '0) && !teardown_pulse) // R6
    else $error("create pulse without functions");

  AST_TEARDOWN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_cmd && is_active && !new_en) |=> (active_cnt == '0) && teardown_pulse) // R7
    else $error("teardown left functions");

  AST_HOLD_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_active && (!ctrl_cmd || new_en)) |=> $stable(active_cnt)) // R11
    else $error("active count moved while enabled");

endmodule

// File: rtl/vfcap_regfile.sv
module vfcap_regfile #(
  parameter int unsigned  ADDR_W    = 12,
  parameter int unsigned  CAP_BASE  = 12'h160,
  parameter int unsigned  CAP_BYTES = 32,
  parameter logic [15:0]  INIT_VFS  = 16'd4,
  parameter logic [15:0]  TOTAL_VFS = 16'd8,
  parameter logic [15:0]  FIRST_OFS = 16'd1,
  parameter logic [15:0]  STRIDE    = 16'd1,
  parameter logic [15:0]  VF_DEVID  = 16'h10ca,
  parameter logic [15:0]  EXTRA_PG  = 16'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              disable_req,
  output logic              vfs_enabled,
  output logic [15:0]       active_vfs,
  output logic              vf_create_pulse,
  output logic              vf_teardown_pulse
);
  import vfcap_pkg::*;

  localparam int unsigned NDW   = CAP_BYTES / 4;
  localparam int unsigned IDX_W = $clog2(NDW);
  localparam logic [FIELD_W-1:0] SUP_PG = PG_MINREQ | EXTRA_PG;

  logic             win_hit;
  logic [IDX_W-1:0] win_idx;
  logic [NDW-1:0]   win_sel;

  logic [FIELD_W-1:0] ctrl_q, numvf_q, syspg_q;
  logic               dis_take, wr_ok;
  logic               ctrl_we, ctrl_cmd, ctrl_new_en;
  logic [1:0]         ctrl_be;
  logic [FIELD_W-1:0] ctrl_d;
  logic               numvf_we, syspg_we, teardown_now;
  logic               unused_hi;

  vfcap_decode #(
    .ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE), .CAP_BYTES(CAP_BYTES)
  ) i_decode (
    .addr(cfg_addr), .hit(win_hit), .idx(win_idx), .sel(win_sel)
  );

  // write steering: a honoured disable request replaces the port write
  always_comb begin
    dis_take    = disable_req && ctrl_q[CTRL_EN_BIT];
    wr_ok       = cfg_wr && !dis_take;
    ctrl_we     = dis_take || (wr_ok && win_sel[DW_CTRL]);
    ctrl_be     = dis_take ? 2'b01 : cfg_be[1:0];
    ctrl_d      = dis_take ? (ctrl_q & ~FIELD_W'(1 << CTRL_EN_BIT)) : cfg_wdata[15:0];
    ctrl_cmd    = dis_take || (wr_ok && win_sel[DW_CTRL] && cfg_be[0]);
    ctrl_new_en = dis_take ? 1'b0 : cfg_wdata[CTRL_EN_BIT];
    numvf_we    = wr_ok && win_sel[DW_NUMVF];
    syspg_we    = wr_ok && win_sel[DW_SYSPG];
    unused_hi   = ^{cfg_be[3:2], cfg_wdata[31:16]};
  end

  vfcap_masked_reg #(.W(FIELD_W), .MASK(CTRL_WMASK), .RST('0)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .byte_en(ctrl_be),
    .d(ctrl_d), .clr(1'b0), .q(ctrl_q)
  );

  vfcap_masked_reg #(.W(FIELD_W), .MASK('1), .RST('0)) i_numvf (
    .clk(clk), .rst_n(rst_n), .we(numvf_we), .byte_en(cfg_be[1:0]),
    .d(cfg_wdata[15:0]), .clr(teardown_now), .q(numvf_q)
  );

  vfcap_masked_reg #(.W(FIELD_W), .MASK(SUP_PG), .RST(SYSPG_RST)) i_syspg (
    .clk(clk), .rst_n(rst_n), .we(syspg_we), .byte_en(cfg_be[1:0]),
    .d(cfg_wdata[15:0]), .clr(1'b0), .q(syspg_q)
  );

  vfcap_enable_ctl #(.CNT_W(FIELD_W)) i_enable (
    .clk(clk), .rst_n(rst_n), .ctrl_cmd(ctrl_cmd), .new_en(ctrl_new_en),
    .req_cnt(numvf_q), .teardown_now(teardown_now), .active_cnt(active_vfs),
    .enabled(vfs_enabled), .create_pulse(vf_create_pulse),
    .teardown_pulse(vf_teardown_pulse)
  );

  // combinational read mux
  always_comb begin
    cfg_rdata = '0;
    if (win_hit) begin
      case (win_idx)
        IDX_W'(DW_CTRL):  cfg_rdata = {16'h0, ctrl_q};
        IDX_W'(DW_COUNT): cfg_rdata = {TOTAL_VFS, INIT_VFS};
        IDX_W'(DW_NUMVF): cfg_rdata = {16'h0, numvf_q};
        IDX_W'(DW_ROUTE): cfg_rdata = {STRIDE, FIRST_OFS};
        IDX_W'(DW_DEVID): cfg_rdata = {VF_DEVID, 16'h0};
        IDX_W'(DW_SUPPG): cfg_rdata = {16'h0, SUP_PG};
        IDX_W'(DW_SYSPG): cfg_rdata = {16'h0, syspg_q};
        default:          cfg_rdata = '0;
      endcase
    end
  end

  AST_TEARDOWN_ZEROES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    vf_teardown_pulse |-> (numvf_q == '0) && (active_vfs == '0)) // R7
    else $error("requested count survived teardown");

  AST_OUTSIDE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !win_hit && !disable_req) |=>
      $stable(ctrl_q) && $stable(numvf_q) && $stable(syspg_q) && $stable(active_vfs)) // R8
    else $error("out-of-window write changed state");

  AST_IDLE_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (disable_req && !ctrl_q[CTRL_EN_BIT] && !cfg_wr) |=>
      $stable(ctrl_q) && $stable(numvf_q)) // R9
    else $error("disable request acted while enable clear");

  AST_DISABLE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (disable_req && ctrl_q[CTRL_EN_BIT]) |=>
      !ctrl_q[CTRL_EN_BIT] && $stable(syspg_q)) // R9
    else $error("disable request did not clear enable");

  AST_SYSPG_IN_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (syspg_q & ~SUP_PG) == '0) // R3
    else $error("system page size outside supported set");

endmodule

// File: tb/test_vfcap_regfile.sv
module test_vfcap_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [11:0] cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        disable_req;
  logic        vfs_enabled;
  logic [15:0] active_vfs;
  logic        vf_create_pulse;
  logic        vf_teardown_pulse;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vfcap_regfile i_vfcap_regfile (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .disable_req(disable_req), .vfs_enabled(vfs_enabled),
    .active_vfs(active_vfs), .vf_create_pulse(vf_create_pulse),
    .vf_teardown_pulse(vf_teardown_pulse)
  );

  // {addr, be, wdata, expected readback}
  localparam int NV = 15;
  localparam logic [79:0] VEC [NV] = '{
    {12'h160, 4'hF, 32'hFFFF_FFFF, 32'h0000_0019},  // R1 only writable ctrl bits
    {12'h160, 4'hF, 32'h0000_0000, 32'h0000_0000},  // R1 clear
    {12'h168, 4'hF, 32'hFFFF_FFFF, 32'h0000_FFFF},  // R2 full width
    {12'h168, 4'h1, 32'h0000_0012, 32'h0000_FF12},  // R10 lane 0 only
    {12'h168, 4'h2, 32'h0000_3400, 32'h0000_3412},  // R10 lane 1 only
    {12'h178, 4'hF, 32'hFFFF_FFFF, 32'h0000_0557},  // R3 mask = supported
    {12'h178, 4'hF, 32'h0000_0002, 32'h0000_0002},  // R3
    {12'h178, 4'h1, 32'h0000_00FF, 32'h0000_0057},  // R3 R10 masked lane
    {12'h174, 4'hF, 32'hFFFF_FFFF, 32'h0000_0557},  // R4 read-only
    {12'h164, 4'hF, 32'h0000_0000, 32'h0008_0004},  // R5 counts
    {12'h16C, 4'hF, 32'h0000_0000, 32'h0001_0001},  // R5 offset, stride
    {12'h170, 4'hF, 32'h0000_0000, 32'h10CA_0000},  // R5 device id
    {12'h17C, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R8 unused dword
    {12'h180, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},  // R8 past window
    {12'h15C, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000}   // R8 below window
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic pulse_disable();
    @(negedge clk);
    disable_req = 1'b1;
    @(negedge clk);
    disable_req = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    n_fail++;
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_be = '0;
    cfg_wdata = '0; disable_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(12'h160, v); chk("R1 reset ctrl", v, 32'h0);
    rd(12'h168, v); chk("R2 reset count", v, 32'h0);
    rd(12'h178, v); chk("R3 reset page size", v, 32'h1);
    chk("R6 reset active", {15'h0, vfs_enabled, active_vfs}, 32'h0);
    chk("R6 R7 reset pulses", {30'h0, vf_create_pulse, vf_teardown_pulse}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][79:68], VEC[i][67:64], VEC[i][63:32]);
      rd(VEC[i][79:68], v);
      chk($sformatf("table row %0d (see row tag)", i), v, VEC[i][31:0]);
    end

    // R8 aliasing writes leave the requested count alone
    wr(12'h168, 4'hF, 32'h3);
    wr(12'h188, 4'hF, 32'hFFFF);
    wr(12'h148, 4'hF, 32'hFFFF);
    rd(12'h168, v); chk("R8 alias writes ignored", v, 32'h3);

    // R6 create
    wr(12'h160, 4'h1, 32'h1);
    chk("R6 create pulse", {31'h0, vf_create_pulse}, 32'h1);
    chk("R6 active count", {16'h0, active_vfs}, 32'h3);
    chk("R6 enabled", {31'h0, vfs_enabled}, 32'h1);
    @(negedge clk);
    chk("R6 pulse one cycle", {31'h0, vf_create_pulse}, 32'h0);

    // R11 rewrite while active
    wr(12'h168, 4'hF, 32'h5);
    wr(12'h160, 4'h1, 32'h9);
    chk("R11 no second create", {31'h0, vf_create_pulse}, 32'h0);
    chk("R11 count held", {16'h0, active_vfs}, 32'h3);
    rd(12'h160, v); chk("R11 ctrl value", v, 32'h9);

    // R10 ctrl write without lane 0
    wr(12'h160, 4'hE, 32'h0);
    chk("R10 no teardown", {16'h0, active_vfs}, 32'h3);
    rd(12'h160, v); chk("R10 ctrl kept", v, 32'h9);

    // R7 teardown
    wr(12'h160, 4'h1, 32'h8);
    chk("R7 teardown pulse", {31'h0, vf_teardown_pulse}, 32'h1);
    chk("R7 active zero", {15'h0, vfs_enabled, active_vfs}, 32'h0);
    rd(12'h168, v); chk("R7 request zeroed", v, 32'h0);
    rd(12'h160, v); chk("R7 ctrl after", v, 32'h8);

    // R6 enable with zero request: nothing created
    wr(12'h160, 4'h1, 32'h1);
    chk("R6 zero request no pulse", {31'h0, vf_create_pulse}, 32'h0);
    chk("R6 zero request inactive", {16'h0, active_vfs}, 32'h0);
    wr(12'h160, 4'h1, 32'h0);

    // R9 disable request while enabled
    wr(12'h168, 4'hF, 32'h2);
    wr(12'h160, 4'h1, 32'h11);
    chk("R9 setup active", {16'h0, active_vfs}, 32'h2);
    pulse_disable();
    chk("R9 teardown pulse", {31'h0, vf_teardown_pulse}, 32'h1);
    chk("R9 active zero", {16'h0, active_vfs}, 32'h0);
    rd(12'h160, v); chk("R9 other bits kept", v, 32'h10);
    rd(12'h168, v); chk("R9 request zeroed", v, 32'h0);

    // R9 disable request while enable clear
    wr(12'h168, 4'hF, 32'h6);
    pulse_disable();
    chk("R9 idle no pulse", {31'h0, vf_teardown_pulse}, 32'h0);
    rd(12'h160, v); chk("R9 idle ctrl", v, 32'h10);
    rd(12'h168, v); chk("R9 idle request", v, 32'h6);

    // R9 concurrent write dropped
    wr(12'h160, 4'h1, 32'h1);
    chk("R9 setup second active", {16'h0, active_vfs}, 32'h6);
    @(negedge clk);
    disable_req = 1'b1; cfg_wr = 1'b1; cfg_addr = 12'h178;
    cfg_be = 4'hF; cfg_wdata = 32'h4;
    @(negedge clk);
    disable_req = 1'b0; cfg_wr = 1'b0;
    chk("R9 concurrent teardown", {31'h0, vf_teardown_pulse}, 32'h1);
    rd(12'h178, v); chk("R9 concurrent write dropped", v, 32'h57);
    rd(12'h160, v); chk("R9 concurrent ctrl", v, 32'h0);

    summary();
    $finish;
  end

endmodule